// File: doc/BRIEF.md
# Banked SRAM Mapper with Controller Window

This block sits between an 8-bit CPU bus (16-bit address, 8-bit data, separate read and write strobes) and two external parts: a battery-backed SRAM of 128 to 1024 KB and a SCSI protocol controller. It divides the CPU range 0x4000–0xBFFF into four 8 KB windows. Each window shows either one 8 KB block of the SRAM or the register set of the controller. The choice for each window is held in a bank register.

Software loads a bank register by writing to 0x6000–0x7FFF. Every write in that range is taken by the mapper and never reaches memory. The bank value also carries a per-window write enable. A separate code in the value replaces the SRAM block with the controller window. The block number is masked to the SRAM capacity set at build time. As a result the values with bit 7 set are writable views of the same blocks that the low values show read-only.

All routing is combinational from the CPU address and the stored bank state. Only the bank registers are clocked.

Top module: `banked_sram_mapper`

## Requirements
- R1: The window index is CPU address bits [15:13] minus 2, giving four 8 KB windows over 0x4000–0xBFFF. For an SRAM-mapped window, `sram_addr` equals stored block × 0x2000 plus CPU address bits [12:0].
- R2: A read outside 0x4000–0xBFFF returns 0xFF on `cpu_rdata`. A write outside that range asserts neither `sram_we` nor `spc_cs`.
- R3: Any CPU write with address in 0x6000–0x7FFF loads bank register number address[12:11] at the clock edge. That write asserts neither `sram_we` nor `spc_cs`, whatever the window maps.
- R4: Bit 7 of a loaded bank value is the window's write enable. A write to an SRAM-mapped window with the enable clear leaves `sram_we` low, and the stored data is unchanged. Reads are not affected.
- R5: A bank value whose bits [7:6] are 01 (0x40–0x7F) maps the controller into the window and stores block 0x7F.
- R6: Any other bank value stores value[6:0] AND (SRAM_KB/8 − 1). A window whose stored block is 0x7F shows the controller, so value 0xFF selects the controller when the SRAM is 1024 KB.
- R7: In a controller window, an access asserts `spc_cs` for that cycle. Offsets below 0x1000 set `spc_dreg`=1 (data register). Other offsets set `spc_dreg`=0 with `spc_reg_idx` = address[3:0]. Reads return `spc_rdata`. The window write enable has no effect on controller writes.
- R8: SRAM_KB must be 128, 256, 512 or 1024. Any other value stops elaboration with an error.
- R9: While `rst` is high, `spc_rst` is high. After reset every window maps block 0 with writes disabled.
- R10: Each read or write strobe produces at most one target access in the same cycle: `sram_we` or `spc_cs`, never both. `spc_cs` is only high while a CPU strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe, one cycle per access |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| sram_addr | output | log2(SRAM_KB)+10 | SRAM byte address |
| sram_wdata | output | 8 | SRAM write data |
| sram_we | output | 1 | SRAM write strobe |
| sram_rdata | input | 8 | SRAM read data (asynchronous) |
| spc_rst | output | 1 | Reset to the controller |
| spc_cs | output | 1 | Controller access strobe |
| spc_we | output | 1 | Controller access direction, 1 = write |
| spc_dreg | output | 1 | Access targets the controller data register |
| spc_reg_idx | output | 4 | Controller register index |
| spc_wdata | output | 8 | Controller write data |
| spc_rdata | input | 8 | Controller read data |

## Verification
Every bank value from 0x00 to 0xFF is loaded into one window of four instances, one for each capacity. A read and a write then follow each load. This separates masking, selection of the controller code, the 0x7F alias at 1024 KB and the write enable, all against arithmetic predictions.

Directed sequences cover the rest:
- Each window is probed at its first, middle and last offsets, which shows the block and offset composition.
- A block is written through its writable alias and then read back through its read-only alias. A blocked write follows, which proves the protection.
- Writes into the bank-register range are made while window 1 shows the controller, which shows that bank loads take priority.
- Accesses at 0x0000, 0x3FFF, 0xC000 and 0xFFFF confirm the inert region.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;

    localparam int NUM_WIN    = 4;
    localparam int SEL_W      = $clog2(NUM_WIN);
    localparam int OFS_W      = 13;
    localparam int BLK_W      = 7;
    localparam logic [BLK_W-1:0] CTRL_BLOCK = 7'h7F;
    localparam logic [7:0]  IDLE_BYTE  = 8'hFF;
    localparam logic [15:0] SPAN_LO    = 16'h4000;
    localparam logic [15:0] SPAN_HI    = 16'hC000;
    localparam logic [2:0]  BANK_PAGE  = 3'b011;

    typedef struct packed {
        logic             wr_en;
        logic [BLK_W-1:0] block;
    } bank_t;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SRAM = 2'd1,
        TGT_CTRL = 2'd2
    } target_e;

    function automatic logic in_span(input logic [15:0] a);
        return (a >= SPAN_LO) && (a < SPAN_HI);
    endfunction

    function automatic logic [SEL_W-1:0] win_of(input logic [15:0] a);
        logic [2:0] page;
        page = a[15:13] - 3'd2;
        return page[SEL_W-1:0];
    endfunction

    function automatic logic is_bank_page(input logic [15:0] a);
        return a[15:13] == BANK_PAGE;
    endfunction

    // R5, R6: turn a written byte into the stored window state
    function automatic bank_t decode_bank(input logic [7:0] v,
                                          input logic [BLK_W-1:0] mask);
        bank_t b;
        b.wr_en = v[7];
        if (v[7:6] == 2'b01)
            b.block = CTRL_BLOCK;
        else
            b.block = v[BLK_W-1:0] & mask;
        return b;
    endfunction

endpackage

// File: rtl/mapper_bank_regs.sv
`timescale 1ns/1ps
module mapper_bank_regs
    import mapper_pkg::*;
#(
    parameter int N_WIN = NUM_WIN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld,
    input  logic [SEL_W-1:0]      ld_sel,
    input  logic [7:0]            ld_val,
    input  logic [BLK_W-1:0]      blk_mask,
    output bank_t                 banks [N_WIN]
);

    logic [N_WIN-1:0] ld_hit;
    bank_t            ld_dec;

    assign ld_dec = decode_bank(ld_val, blk_mask);

    for (genvar w = 0; w < N_WIN; w++) begin : g_ld
        assign ld_hit[w] = ld && (ld_sel == SEL_W'(w));
    end

    // R9: reset state is block 0, writes disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < N_WIN; w++) begin
                banks[w] <= '0;
            end
        end else begin
            for (int w = 0; w < N_WIN; w++) begin
                if (ld_hit[w]) begin
                    banks[w] <= ld_dec;
                end
            end
        end
    end

endmodule

// File: rtl/mapper_decode.sv
`timescale 1ns/1ps
module mapper_decode
    import mapper_pkg::*;
#(
    parameter int N_WIN  = NUM_WIN,
    parameter int ADDR_W = 20
) (
    input  logic [15:0]        cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  bank_t              banks [N_WIN],
    output logic               bank_ld,
    output logic [SEL_W-1:0]   bank_sel,
    output target_e            target,
    output logic               sram_we,
    output logic               ctrl_cs,
    output logic [ADDR_W-1:0]  sram_addr,
    output logic [3:0]         reg_idx,
    output logic               dreg_sel
);

    localparam int BW = ADDR_W - OFS_W;

    logic             span;
    logic             bank_page;
    logic [SEL_W-1:0] win;
    bank_t            cur;
    logic             is_ctrl;
    logic [OFS_W-1:0] ofs;

    always_comb begin
        span      = in_span(cpu_addr);
        bank_page = is_bank_page(cpu_addr);
        win       = win_of(cpu_addr);
        cur       = banks[win];
        ofs       = cpu_addr[OFS_W-1:0];
        is_ctrl   = (cur.block == CTRL_BLOCK);

        // R3: bank loads sit in window 1 and take every write there
        bank_ld   = cpu_wr && bank_page;
        bank_sel  = cpu_addr[12:11];

        if (!span)
            target = TGT_NONE;
        else if (is_ctrl)
            target = TGT_CTRL;
        else
            target = TGT_SRAM;

        // R1
        sram_addr = {cur.block[BW-1:0], ofs};

        // R4
        sram_we   = cpu_wr && !bank_page && (target == TGT_SRAM) && cur.wr_en;

        // R7, R10
        ctrl_cs   = (target == TGT_CTRL) && (cpu_rd || (cpu_wr && !bank_page));
        dreg_sel  = (ofs < 13'h1000);
        reg_idx   = ofs[3:0];
    end

endmodule

// File: rtl/mapper_rdmux.sv
`timescale 1ns/1ps
module mapper_rdmux
    import mapper_pkg::*;
(
    input  target_e      target,
    input  logic [7:0]   sram_rdata,
    input  logic [7:0]   ctrl_rdata,
    output logic [7:0]   cpu_rdata
);

    // R2, R7
    always_comb begin
        unique case (target)
            TGT_SRAM: cpu_rdata = sram_rdata;
            TGT_CTRL: cpu_rdata = ctrl_rdata;
            default:  cpu_rdata = IDLE_BYTE;
        endcase
    end

endmodule

// File: rtl/banked_sram_mapper.sv
`timescale 1ns/1ps
module banked_sram_mapper
    import mapper_pkg::*;
#(
    parameter int SRAM_KB = 1024
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [15:0]                cpu_addr,
    input  logic [7:0]                 cpu_wdata,
    input  logic                       cpu_rd,
    input  logic                       cpu_wr,
    output logic [7:0]                 cpu_rdata,
    output logic [$clog2(SRAM_KB)+9:0] sram_addr,
    output logic [7:0]                 sram_wdata,
    output logic                       sram_we,
    input  logic [7:0]                 sram_rdata,
    output logic                       spc_rst,
    output logic                       spc_cs,
    output logic                       spc_we,
    output logic                       spc_dreg,
    output logic [3:0]                 spc_reg_idx,
    output logic [7:0]                 spc_wdata,
    input  logic [7:0]                 spc_rdata
);

    localparam int ADDR_W = $clog2(SRAM_KB) + 10;
    localparam int N_BLK  = SRAM_KB / 8;
    localparam logic [BLK_W-1:0] BLK_MASK = BLK_W'(N_BLK - 1);
    localparam bit SIZE_OK = (SRAM_KB == 128) || (SRAM_KB == 256) ||
                             (SRAM_KB == 512) || (SRAM_KB == 1024);

    // R8: reject unsupported capacities at elaboration
    if (!SIZE_OK) begin : g_bad_size
        $error("banked_sram_mapper: SRAM_KB must be 128, 256, 512 or 1024");
    end

    bank_t            banks [NUM_WIN];
    logic             bank_ld;
    logic [SEL_W-1:0] bank_sel;
    target_e          target;
    logic             ctrl_cs;
    logic             dreg_sel;
    logic [3:0]       reg_idx;
    logic [ADDR_W-1:0] s_addr;
    logic             s_we;

    mapper_bank_regs #(
        .N_WIN    (NUM_WIN)
    ) u_banks (
        .clk      (clk),
        .rst      (rst),
        .ld       (bank_ld),
        .ld_sel   (bank_sel),
        .ld_val   (cpu_wdata),
        .blk_mask (BLK_MASK),
        .banks    (banks)
    );

    mapper_decode #(
        .N_WIN    (NUM_WIN),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .banks    (banks),
        .bank_ld  (bank_ld),
        .bank_sel (bank_sel),
        .target   (target),
        .sram_we  (s_we),
        .ctrl_cs  (ctrl_cs),
        .sram_addr(s_addr),
        .reg_idx  (reg_idx),
        .dreg_sel (dreg_sel)
    );

    mapper_rdmux u_rdmux (
        .target     (target),
        .sram_rdata (sram_rdata),
        .ctrl_rdata (spc_rdata),
        .cpu_rdata  (cpu_rdata)
    );

    assign sram_addr   = s_addr;
    assign sram_we     = s_we;
    assign sram_wdata  = cpu_wdata;
    assign spc_rst     = rst;          // R9
    assign spc_cs      = ctrl_cs;
    assign spc_we      = cpu_wr;
    assign spc_dreg    = dreg_sel;
    assign spc_reg_idx = reg_idx;
    assign spc_wdata   = cpu_wdata;

endmodule

// File: rtl/mapper_checker.sv
`timescale 1ns/1ps
module mapper_checker
    import mapper_pkg::*;
#(
    parameter int SRAM_KB = 1024
) (
    input logic                       clk,
    input logic                       rst,
    input logic [15:0]                cpu_addr,
    input logic [7:0]                 cpu_wdata,
    input logic                       cpu_rd,
    input logic                       cpu_wr,
    input logic [7:0]                 cpu_rdata,
    input logic [$clog2(SRAM_KB)+9:0] sram_addr,
    input logic                       sram_we,
    input logic                       spc_cs,
    input logic                       spc_dreg,
    input logic [3:0]                 spc_reg_idx
);

    localparam logic [6:0] MASK = 7'(SRAM_KB / 8 - 1);

    logic [3:0] we_sh;
    logic [3:0] ctrl_sh;
    logic [1:0] w_now;
    logic       oob;
    logic       bank_wr;

    assign w_now   = 2'(cpu_addr[15:13] - 3'd2);
    assign oob     = (cpu_addr < 16'h4000) || (cpu_addr >= 16'hC000);
    assign bank_wr = cpu_wr && (cpu_addr[15:12] == 4'h6 || cpu_addr[15:12] == 4'h7);

    always_ff @(posedge clk) begin
        if (rst) begin
            we_sh   <= '0;
            ctrl_sh <= '0;
        end else if (bank_wr) begin
            we_sh[cpu_addr[12:11]]   <= cpu_wdata[7];
            ctrl_sh[cpu_addr[12:11]] <= (cpu_wdata[7:6] == 2'b01) ||
                                        ((cpu_wdata[6:0] & MASK) == 7'h7F);
        end
    end

    p_oob_read_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && oob) |-> (cpu_rdata == 8'hFF));

    p_oob_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        oob |-> (!sram_we && !spc_cs));

    p_bank_wr_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        bank_wr |-> (!sram_we && !spc_cs));

    p_write_protect_r4: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> we_sh[w_now]);

    p_ctrl_select_r6: assert property (@(posedge clk) disable iff (rst)
        (!oob && (cpu_rd || (cpu_wr && !bank_wr))) |-> (spc_cs == ctrl_sh[w_now]));

    p_sram_offset_r1: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (sram_addr[12:0] == cpu_addr[12:0]));

    p_dreg_r7: assert property (@(posedge clk) disable iff (rst)
        spc_cs |-> (spc_dreg == !cpu_addr[12]));

    p_reg_idx_r7: assert property (@(posedge clk) disable iff (rst)
        (spc_cs && cpu_addr[12]) |-> (spc_reg_idx == cpu_addr[3:0]));

    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        !(sram_we && spc_cs));

    p_cs_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        spc_cs |-> (cpu_rd || cpu_wr));

endmodule

bind banked_sram_mapper mapper_checker #(.SRAM_KB(SRAM_KB)) u_chk (.*);

// File: tb/banked_sram_mapper_tb.sv
`timescale 1ns/1ps
module banked_sram_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;

    logic [7:0]  rdata;
    logic [16:0] sa;
    logic [7:0]  s_wd;
    logic        s_we;
    logic [7:0]  s_rd;
    logic        c_rst, c_cs, c_we, c_dreg;
    logic [3:0]  c_idx;
    logic [7:0]  c_wd;
    logic [7:0]  c_rd;

    logic [17:0] sa2; logic we2, cs2;
    logic [18:0] sa3; logic we3, cs3;
    logic [19:0] sa4; logic we4, cs4;
    logic [7:0]  nc_rdata2, nc_rdata3, nc_rdata4, nc_wd2, nc_wd3, nc_wd4;
    logic [7:0]  nc_cwd2, nc_cwd3, nc_cwd4;
    logic        nc_r2, nc_r3, nc_r4, nc_w2, nc_w3, nc_w4, nc_d2, nc_d3, nc_d4;
    logic [3:0]  nc_i2, nc_i3, nc_i4;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    banked_sram_mapper #(.SRAM_KB(128)) u_dut (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rd(rd), .cpu_wr(wr), .cpu_rdata(rdata),
        .sram_addr(sa), .sram_wdata(s_wd), .sram_we(s_we), .sram_rdata(s_rd),
        .spc_rst(c_rst), .spc_cs(c_cs), .spc_we(c_we), .spc_dreg(c_dreg),
        .spc_reg_idx(c_idx), .spc_wdata(c_wd), .spc_rdata(c_rd));

    banked_sram_mapper #(.SRAM_KB(256)) u_k256 (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rd(rd), .cpu_wr(wr), .cpu_rdata(nc_rdata2),
        .sram_addr(sa2), .sram_wdata(nc_wd2), .sram_we(we2), .sram_rdata(8'h00),
        .spc_rst(nc_r2), .spc_cs(cs2), .spc_we(nc_w2), .spc_dreg(nc_d2),
        .spc_reg_idx(nc_i2), .spc_wdata(nc_cwd2), .spc_rdata(8'h00));

    banked_sram_mapper #(.SRAM_KB(512)) u_k512 (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rd(rd), .cpu_wr(wr), .cpu_rdata(nc_rdata3),
        .sram_addr(sa3), .sram_wdata(nc_wd3), .sram_we(we3), .sram_rdata(8'h00),
        .spc_rst(nc_r3), .spc_cs(cs3), .spc_we(nc_w3), .spc_dreg(nc_d3),
        .spc_reg_idx(nc_i3), .spc_wdata(nc_cwd3), .spc_rdata(8'h00));

    banked_sram_mapper #(.SRAM_KB(1024)) u_k1024 (
        .clk(clk), .rst(rst), .cpu_addr(addr), .cpu_wdata(wdata),
        .cpu_rd(rd), .cpu_wr(wr), .cpu_rdata(nc_rdata4),
        .sram_addr(sa4), .sram_wdata(nc_wd4), .sram_we(we4), .sram_rdata(8'h00),
        .spc_rst(nc_r4), .spc_cs(cs4), .spc_we(nc_w4), .spc_dreg(nc_d4),
        .spc_reg_idx(nc_i4), .spc_wdata(nc_cwd4), .spc_rdata(8'h00));

    // Sparse SRAM model: block[3:0] and offset[3:0] of the 128 KB part
    logic [7:0] smem [256];
    assign s_rd = smem[{sa[16:13], sa[3:0]}];
    always @(posedge clk) if (s_we) smem[{sa[16:13], sa[3:0]}] <= s_wd;

    // Controller register model: 16 registers plus a data register
    logic [7:0] cregs [16];
    logic [7:0] cdata;
    assign c_rd = c_dreg ? cdata : cregs[c_idx];
    always @(posedge clk) begin
        if (c_cs && c_we) begin
            if (c_dreg) cdata <= c_wd;
            else        cregs[c_idx] <= c_wd;
        end
    end

    // Values sampled during the last access
    logic [7:0]  o_rdata;
    logic [16:0] o_sa;
    logic        o_we, o_cs, o_dreg;
    logic [3:0]  o_idx;
    logic [19:0] o_sa_k [4];
    logic        o_we_k [4];
    logic        o_cs_k [4];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [15:0] a, input logic [7:0] d, input bit is_wr);
        @(negedge clk);
        addr = a; wdata = d; rd = !is_wr; wr = is_wr;
        #2;
        o_rdata = rdata; o_sa = sa; o_we = s_we; o_cs = c_cs;
        o_dreg = c_dreg; o_idx = c_idx;
        o_sa_k[0] = 20'(sa);  o_we_k[0] = s_we; o_cs_k[0] = c_cs;
        o_sa_k[1] = 20'(sa2); o_we_k[1] = we2;  o_cs_k[1] = cs2;
        o_sa_k[2] = 20'(sa3); o_we_k[2] = we3;  o_cs_k[2] = cs3;
        o_sa_k[3] = sa4;      o_we_k[3] = we4;  o_cs_k[3] = cs4;
        @(posedge clk);
        #1;
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic set_bank(input int w, input logic [7:0] v);
        access(16'h6000 + 16'(w * 16'h0800), v, 1'b1);
        chk("R3 bank load sram_we", 32'(o_we), 32'd0);
        chk("R3 bank load spc_cs", 32'(o_cs), 32'd0);
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        for (int i = 0; i < 16; i++) cregs[i] = 8'(8'h30 + i);
        cdata = 8'hC5;

        repeat (3) @(posedge clk);
        #1;
        chk("R9 spc_rst during reset", 32'(c_rst), 32'd1);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R9 spc_rst released", 32'(c_rst), 32'd0);

        // R9: every window at block 0, no controller, writes blocked
        for (int w = 0; w < 4; w++) begin
            access(16'h4000 + 16'(w * 16'h2000) + 16'h0123, 8'h00, 1'b0);
            chk("R9 reset block 0", 32'(o_sa), 32'h0123);
            chk("R9 reset not ctrl", 32'(o_cs), 32'd0);
        end
        access(16'h4005, 8'h11, 1'b1);
        chk("R9 R4 reset write disabled", 32'(o_we), 32'd0);

        // R1: window composition at boundary offsets
        for (int w = 0; w < 4; w++) set_bank(w, 8'(8'h80 + w + 3));
        for (int w = 0; w < 4; w++) begin
            for (int k = 0; k < 4; k++) begin
                logic [15:0] ofs;
                ofs = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0FFF :
                      (k == 2) ? 16'h1000 : 16'h1FFF;
                access(16'h4000 + 16'(w * 16'h2000) + ofs, 8'h00, 1'b0);
                chk("R1 sram address", 32'(o_sa), 32'((w + 3) * 32'h2000) + 32'(ofs));
            end
        end

        // R4: writable alias writes, read-only alias blocks
        set_bank(0, 8'h85);
        access(16'h4007, 8'h5A, 1'b1);
        chk("R4 writable window sram_we", 32'(o_we), 32'd1);
        set_bank(0, 8'h05);
        access(16'h4007, 8'hA5, 1'b0);
        chk("R4 R6 read-only alias sees data", 32'(o_rdata), 32'h5A);
        access(16'h4007, 8'hA5, 1'b1);
        chk("R4 protected write sram_we", 32'(o_we), 32'd0);
        access(16'h4007, 8'h00, 1'b0);
        chk("R4 data unchanged", 32'(o_rdata), 32'h5A);

        // R5, R7: controller window in window 2, write enable clear
        set_bank(2, 8'h40);
        access(16'h8003, 8'h9E, 1'b1);
        chk("R7 data reg write cs", 32'(o_cs), 32'd1);
        chk("R7 data reg select", 32'(o_dreg), 32'd1);
        chk("R5 ctrl write no sram", 32'(o_we), 32'd0);
        access(16'h8FFF, 8'h00, 1'b0);
        chk("R7 data reg read", 32'(o_rdata), 32'h9E);
        access(16'h9003, 8'h77, 1'b1);
        chk("R7 reg idx", 32'(o_idx), 32'd3);
        chk("R7 reg select", 32'(o_dreg), 32'd0);
        access(16'h9FF3, 8'h00, 1'b0);
        chk("R7 reg read mirror", 32'(o_rdata), 32'h77);
        access(16'h9FFF, 8'h00, 1'b0);
        chk("R7 reg idx F", 32'(o_rdata), 32'h3F);

        // R3: window 1 as controller, writes there still load banks
        set_bank(1, 8'h7F);
        access(16'h7005, 8'h00, 1'b0);
        chk("R5 window1 ctrl read cs", 32'(o_cs), 32'd1);
        chk("R7 window1 ctrl read", 32'(o_rdata), 32'h35);
        access(16'h7005, 8'h83, 1'b1);
        chk("R3 priority no cs", 32'(o_cs), 32'd0);
        chk("R3 priority no sram", 32'(o_we), 32'd0);
        access(16'h8010, 8'h00, 1'b0);
        chk("R3 addr[12:11] selects window 2", 32'(o_sa), 32'h6010);
        access(16'h67FF, 8'h82, 1'b1);
        access(16'h4010, 8'h00, 1'b0);
        chk("R3 0x67FF loads window 0", 32'(o_sa), 32'h4010);

        // R2: outside span
        for (int k = 0; k < 4; k++) begin
            logic [15:0] a;
            a = (k == 0) ? 16'h0000 : (k == 1) ? 16'h3FFF :
                (k == 2) ? 16'hC000 : 16'hFFFF;
            access(a, 8'h00, 1'b0);
            chk("R2 idle read", 32'(o_rdata), 32'hFF);
            access(a, 8'h12, 1'b1);
            chk("R2 idle write sram", 32'(o_we), 32'd0);
            chk("R2 idle write cs", 32'(o_cs), 32'd0);
        end

        // R6, R10: every bank value on all capacities
        for (int v = 0; v < 256; v++) begin
            set_bank(0, 8'(v));
            access(16'h4100, 8'h00, 1'b0);
            for (int c = 0; c < 4; c++) begin
                int   mask;
                int   blk;
                logic ctrl;
                mask = (128 << c) / 8 - 1;
                blk  = v & mask;
                ctrl = ((v >> 6) == 1) || ((blk & 8'h7F) == 8'h7F);
                chk("R6 R5 ctrl select", 32'(o_cs_k[c]), 32'(ctrl));
                if (!ctrl)
                    chk("R6 masked block", 32'(o_sa_k[c]), 32'(blk * 32'h2000 + 32'h100));
            end
            access(16'h4100, 8'h66, 1'b1);
            for (int c = 0; c < 4; c++) begin
                int   mask;
                logic ctrl;
                mask = (128 << c) / 8 - 1;
                ctrl = ((v >> 6) == 1) || (((v & mask) & 8'h7F) == 8'h7F);
                chk("R4 write enable per value", 32'(o_we_k[c]), 32'((v >= 128) && !ctrl));
                chk("R10 single target", 32'(o_we_k[c] && o_cs_k[c]), 32'd0);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule